// File: doc/BRIEF.md
# Speculative and Committed Store Buffer

This block sits between the execute stage and the data-cache write port of a pipelined core. Stores arrive from execute while they are still speculative. Each accepted store is held in a speculative region until the commit logic retires it. A commit pulse moves the oldest speculative store into a committed region. Any store in the committed region is sent to the cache in age order through a request/grant handshake.

Incoming stores are checked for natural alignment. A misaligned store is reported on a dedicated flag and is not stored. An aligned store gets a byte-enable mask built from its size and byte offset. A flush drops every speculative store in one cycle and keeps the committed ones.

A load unit can present a doubleword address at any time. The block reports whether any pending store in either region falls in the same doubleword. Two flags tell the pipeline when the committed region is empty and when the whole buffer is empty.

Top module: `spec_store_queue`

## Requirements
- R1: After reset the buffer reports both empty flags high, `dc_req_o` low, `chk_hit_o` low and `st_ready_o` high.
- R2: An accepted store goes into the speculative region. It never raises `dc_req_o` until a commit pulse has promoted it.
- R3: When `commit_i` is high, `flush_i` is low and the speculative region is not empty, the oldest speculative store moves to the committed region at that clock edge. Stores leave the buffer for the cache in the order they were accepted.
- R4: While the committed region holds an entry, `dc_req_o` is high and presents the oldest committed address, data and byte enables. These stay unchanged until `dc_gnt_i` is sampled high. The entry is removed at that grant edge and at no other time.
- R5: `st_size_i` is encoded 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. When `st_valid_i` is high, `st_misalign_o` is high in the same cycle for a halfword with address bit 0 set, a word with address bits [1:0] nonzero, or a doubleword with address bits [2:0] nonzero. Such a store is not stored.
- R6: The byte-enable mask of a stored entry covers 1, 2, 4 or 8 bytes for size 0, 1, 2 or 3. The mask is shifted left by address bits [2:0]. For example, a byte at offset 3 gives 0x08, a halfword at offset 6 gives 0xC0, a word at offset 4 gives 0xF0, and a doubleword gives 0xFF.
- R7: `st_ready_o` is low while the speculative region holds SPEC_DEPTH (4) entries. A store offered then is not accepted.
- R8: A flush discards all speculative entries at the clock edge. It keeps every committed entry. A store or a commit in the flush cycle is dropped, and `st_ready_o` is low during a flush.
- R9: `chk_hit_o` is high, in the same cycle, exactly when some pending entry in either region has address bits [63:3] equal to `chk_dw_i`.
- R10: `commit_empty_o` is high when the committed region holds no entry. `empty_o` is high when neither region holds an entry.
- R11: A commit pulse while the speculative region is empty has no effect. The commit logic must not commit while the committed region is full unless a grant arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard all speculative stores |
| st_valid_i | input | 1 | Store offered by execute |
| st_ready_o | output | 1 | Store can be accepted this cycle |
| st_addr_i | input | 64 | Store byte address |
| st_data_i | input | 64 | Store data, already lane-aligned |
| st_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| st_misalign_o | output | 1 | Offered store is misaligned and is rejected |
| commit_i | input | 1 | Promote the oldest speculative store |
| dc_req_o | output | 1 | Cache write request |
| dc_addr_o | output | 64 | Cache write address |
| dc_data_o | output | 64 | Cache write data |
| dc_be_o | output | 8 | Cache write byte enables |
| dc_gnt_i | input | 1 | Cache accepts the presented write |
| chk_dw_i | input | 61 | Load doubleword address (byte address bits 63:3) |
| chk_hit_o | output | 1 | Some pending store hits that doubleword |
| commit_empty_o | output | 1 | Committed region empty |
| empty_o | output | 1 | Whole buffer empty |

## Verification
The bench first holds a store uncommitted for several cycles and then holds its grant low. A design that leaked speculative stores or dropped an entry before the grant would raise or release the cache request in the wrong cycle.

It fills the speculative region and offers a fifth store. A design with an off-by-one full test would accept that store, and an extra write would appear at drain.

It flushes with both regions occupied. A design that cleared the wrong region would lose a committed write or keep a squashed one.

It also checks each alignment rule at its edge and each byte-enable shape. The alias test probes both regions and a neighbouring doubleword, which catches a compare that covers only one region or that includes the low address bits.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(BE_W);
  localparam int unsigned DW_W   = ADDR_W - OFF_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } st_size_e;

  // Address is the most significant field so that a slot's upper bits
  // carry the doubleword address used by the alias compare.
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } st_entry_t;

  localparam int unsigned ENTRY_W = $bits(st_entry_t);
endpackage

// File: rtl/ssq_align.sv
module ssq_align
  import ssq_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misalign_o,
  output logic [BE_W-1:0]  be_o
);
  st_size_e        size;
  logic [BE_W-1:0] base_mask;

  assign size = st_size_e'(size_i);

  always_comb begin
    misalign_o = 1'b0;
    base_mask  = '0;
    unique case (size)
      SZ_BYTE: begin
        base_mask  = BE_W'(8'h01);
      end
      SZ_HALF: begin
        base_mask  = BE_W'(8'h03);
        misalign_o = off_i[0];
      end
      SZ_WORD: begin
        base_mask  = BE_W'(8'h0F);
        misalign_o = |off_i[1:0];
      end
      SZ_DBL: begin
        base_mask  = BE_W'(8'hFF);
        misalign_o = |off_i;
      end
      default: begin
        base_mask  = '0;
        misalign_o = 1'b1;
      end
    endcase
    be_o = base_mask << off_i;
  end
endmodule

// File: rtl/ssq_fifo.sv
module ssq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   push_i,
  input  logic [W-1:0]           wdata_i,
  input  logic                   pop_i,
  output logic [W-1:0]           rdata_o,
  output logic                   full_o,
  output logic                   empty_o,
  output logic [DEPTH-1:0]       valid_o,
  output logic [DEPTH*TAG_W-1:0] tags_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  mem_q [DEPTH];
  logic          wr_en;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rd_q];
  assign wr_en   = push_i && !clear_i;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      rd_d  = wr_q;
      cnt_d = '0;
    end else begin
      if (push_i) wr_d = wr_q + PW'(1);
      if (pop_i)  rd_d = rd_q + PW'(1);
      cnt_d = cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q] <= wdata_i;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [PW-1:0] rel;
    assign rel        = PW'(g) - rd_q;
    assign valid_o[g] = (CW'(rel) < cnt_q);
    assign tags_o[g*TAG_W +: TAG_W] = mem_q[g][W-1 -: TAG_W];
  end

  // R7 / R11: a write into a full region must be matched by a read
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !clear_i) |-> pop_i);

  // R4: entries leave only when present
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  initial begin
    assert_depth_pow2_R7: assert ((DEPTH & (DEPTH - 1)) == 0);
  end
endmodule

// File: rtl/ssq_alias.sv
module ssq_alias #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAG_W = 61
) (
  input  logic [N*TAG_W-1:0] tags_i,
  input  logic [N-1:0]       valid_i,
  input  logic [TAG_W-1:0]   probe_i,
  output logic               hit_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g*TAG_W +: TAG_W] == probe_i);
  end

  assign hit_o = |match;
endmodule

// File: rtl/spec_store_queue.sv
module spec_store_queue
  import ssq_pkg::*;
#(
  parameter int unsigned SPEC_DEPTH   = 4,
  parameter int unsigned COMMIT_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [1:0]        st_size_i,
  output logic              st_misalign_o,
  input  logic              commit_i,
  output logic              dc_req_o,
  output logic [ADDR_W-1:0] dc_addr_o,
  output logic [DATA_W-1:0] dc_data_o,
  output logic [BE_W-1:0]   dc_be_o,
  input  logic              dc_gnt_i,
  input  logic [DW_W-1:0]   chk_dw_i,
  output logic              chk_hit_o,
  output logic              commit_empty_o,
  output logic              empty_o
);
  localparam int unsigned TOTAL = SPEC_DEPTH + COMMIT_DEPTH;

  logic            misalign;
  logic [BE_W-1:0] new_be;
  st_entry_t       new_entry, spec_head, cmt_head;
  logic [ENTRY_W-1:0] spec_rdata, cmt_rdata;

  logic spec_push, spec_pop, spec_full, spec_empty;
  logic cmt_push, cmt_pop, cmt_full, cmt_empty;
  logic [SPEC_DEPTH-1:0]        spec_valid;
  logic [COMMIT_DEPTH-1:0]      cmt_valid;
  logic [SPEC_DEPTH*DW_W-1:0]   spec_tags;
  logic [COMMIT_DEPTH*DW_W-1:0] cmt_tags;

  ssq_align u_align (
    .size_i     (st_size_i),
    .off_i      (st_addr_i[OFF_W-1:0]),
    .misalign_o (misalign),
    .be_o       (new_be)
  );

  assign st_misalign_o = st_valid_i && misalign;
  assign st_ready_o    = !spec_full && !flush_i;
  assign spec_push     = st_valid_i && st_ready_o && !misalign;
  assign spec_pop      = commit_i && !spec_empty && !flush_i;
  assign cmt_push      = spec_pop;
  assign cmt_pop       = dc_gnt_i && !cmt_empty;

  always_comb begin
    new_entry.addr = st_addr_i;
    new_entry.data = st_data_i;
    new_entry.be   = new_be;
  end

  ssq_fifo #(.W(ENTRY_W), .DEPTH(SPEC_DEPTH), .TAG_W(DW_W)) u_spec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (flush_i),
    .push_i  (spec_push),
    .wdata_i (new_entry),
    .pop_i   (spec_pop),
    .rdata_o (spec_rdata),
    .full_o  (spec_full),
    .empty_o (spec_empty),
    .valid_o (spec_valid),
    .tags_o  (spec_tags)
  );

  assign spec_head = st_entry_t'(spec_rdata);

  ssq_fifo #(.W(ENTRY_W), .DEPTH(COMMIT_DEPTH), .TAG_W(DW_W)) u_cmt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (1'b0),
    .push_i  (cmt_push),
    .wdata_i (spec_head),
    .pop_i   (cmt_pop),
    .rdata_o (cmt_rdata),
    .full_o  (cmt_full),
    .empty_o (cmt_empty),
    .valid_o (cmt_valid),
    .tags_o  (cmt_tags)
  );

  assign cmt_head       = st_entry_t'(cmt_rdata);
  assign dc_req_o       = !cmt_empty;
  assign dc_addr_o      = cmt_head.addr;
  assign dc_data_o      = cmt_head.data;
  assign dc_be_o        = cmt_head.be;
  assign commit_empty_o = cmt_empty;
  assign empty_o        = cmt_empty && spec_empty;

  ssq_alias #(.N(TOTAL), .TAG_W(DW_W)) u_alias (
    .tags_i  ({cmt_tags, spec_tags}),
    .valid_i ({cmt_valid, spec_valid}),
    .probe_i (chk_dw_i),
    .hit_o   (chk_hit_o)
  );

  // R4: an ungranted request holds its payload
  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_req_o && !dc_gnt_i) |=> (dc_req_o && $stable(dc_addr_o)
                                 && $stable(dc_data_o) && $stable(dc_be_o)));

  // R2: without a commit nothing reaches the cache port
  assert_spec_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_empty_o && !commit_i) |=> !dc_req_o);

  // R5: a rejected store leaves the speculative region untouched
  assert_misalign_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_misalign_o && !commit_i && !flush_i) |=> $stable(spec_valid));

  // R8: flush never removes committed work
  assert_flush_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !commit_empty_o && !dc_gnt_i) |=> !commit_empty_o);

  // R11: commit with no speculative entry leaves the committed region alone
  assert_idle_commit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && spec_empty && !cmt_full && !dc_gnt_i) |=> $stable(cmt_valid));
endmodule

// File: tb/spec_store_queue_tb.sv
module spec_store_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, st_valid, st_ready, st_misalign, commit;
  logic [63:0] st_addr, st_data;
  logic [1:0]  st_size;
  logic        dc_req, dc_gnt, chk_hit, commit_empty, empty;
  logic [63:0] dc_addr, dc_data;
  logic [7:0]  dc_be;
  logic [60:0] chk_dw;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  spec_store_queue u_dut (
    .clk_i (clk), .rst_ni (rst_n), .flush_i (flush),
    .st_valid_i (st_valid), .st_ready_o (st_ready), .st_addr_i (st_addr),
    .st_data_i (st_data), .st_size_i (st_size), .st_misalign_o (st_misalign),
    .commit_i (commit), .dc_req_o (dc_req), .dc_addr_o (dc_addr),
    .dc_data_o (dc_data), .dc_be_o (dc_be), .dc_gnt_i (dc_gnt),
    .chk_dw_i (chk_dw), .chk_hit_o (chk_hit),
    .commit_empty_o (commit_empty), .empty_o (empty)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  task automatic push(logic [63:0] a, logic [63:0] d, logic [1:0] sz);
    st_valid = 1'b1; st_addr = a; st_data = d; st_size = sz;
    tick();
    st_valid = 1'b0;
  endtask

  task automatic do_commit();
    commit = 1'b1;
    tick();
    commit = 1'b0;
  endtask

  task automatic drain_one(string tag, logic [63:0] a, logic [63:0] d, logic [7:0] be);
    #1;
    check({tag, " req"}, dc_req, 1);
    check({tag, " addr"}, dc_addr, a);
    check({tag, " data"}, dc_data, d);
    check({tag, " be"}, dc_be, be);
    dc_gnt = 1'b1;
    tick();
    dc_gnt = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 empty", empty, 1);
    check("R1 commit_empty", commit_empty, 1);
    check("R1 req", dc_req, 0);
    check("R1 ready", st_ready, 1);
    check("R1 hit", chk_hit, 0);
  endtask

  task automatic t_spec_hold();
    push(64'h1000, 64'hA1A2_A3A4_A5A6_A7A8, 2'd3);
    #1;
    check("R10 not empty", empty, 0);
    check("R10 commit_empty", commit_empty, 1);
    check("R2 no req", dc_req, 0);
    tick(); tick();
    check("R2 still no req", dc_req, 0);
    do_commit();
    #1;
    check("R3 req after commit", dc_req, 1);
    check("R10 commit not empty", commit_empty, 0);
    tick(); tick();
    check("R4 req held", dc_req, 1);
    check("R4 addr held", dc_addr, 64'h1000);
    drain_one("R4 drain", 64'h1000, 64'hA1A2_A3A4_A5A6_A7A8, 8'hFF);
    #1;
    check("R4 removed on grant", dc_req, 0);
    check("R10 empty after drain", empty, 1);
  endtask

  task automatic t_byte_enables();
    push(64'h2003, 64'h11, 2'd0);
    push(64'h2006, 64'h22, 2'd1);
    push(64'h2004, 64'h33, 2'd2);
    push(64'h2008, 64'h44, 2'd3);
    repeat (4) do_commit();
    drain_one("R6 R3 byte", 64'h2003, 64'h11, 8'h08);
    drain_one("R6 R3 half", 64'h2006, 64'h22, 8'hC0);
    drain_one("R6 R3 word", 64'h2004, 64'h33, 8'hF0);
    drain_one("R6 R3 dbl",  64'h2008, 64'h44, 8'hFF);
    #1;
    check("R3 order done", empty, 1);
  endtask

  task automatic t_misalign();
    st_valid = 1'b1; st_data = 64'h55;
    st_addr = 64'h3001; st_size = 2'd1; #1;
    check("R5 half odd", st_misalign, 1);
    st_addr = 64'h3002; st_size = 2'd2; #1;
    check("R5 word off2", st_misalign, 1);
    st_addr = 64'h3004; st_size = 2'd3; #1;
    check("R5 dbl off4", st_misalign, 1);
    tick();
    st_valid = 1'b0;
    #1;
    check("R5 nothing stored", empty, 1);
    st_valid = 1'b1; st_addr = 64'h3007; st_size = 2'd0; #1;
    check("R5 byte odd ok", st_misalign, 0);
    st_addr = 64'h3004; st_size = 2'd2; #1;
    check("R5 word off4 ok", st_misalign, 0);
    st_valid = 1'b0;
  endtask

  task automatic t_full();
    for (int i = 0; i < 4; i++) push(64'h4000 + 64'(i) * 8, 64'(i) + 64'h100, 2'd3);
    #1;
    check("R7 ready low when full", st_ready, 0);
    push(64'h4100, 64'hDEAD, 2'd3);
    repeat (4) do_commit();
    #1;
    check("R7 ready back", st_ready, 1);
    for (int i = 0; i < 4; i++)
      drain_one("R7 drain", 64'h4000 + 64'(i) * 8, 64'(i) + 64'h100, 8'hFF);
    #1;
    check("R7 fifth store dropped", empty, 1);
  endtask

  task automatic t_flush();
    push(64'h5000, 64'h1, 2'd3);
    push(64'h5008, 64'h2, 2'd3);
    do_commit();
    push(64'h5010, 64'h3, 2'd3);
    flush = 1'b1; commit = 1'b1; st_valid = 1'b1; st_addr = 64'h5018; st_size = 2'd3;
    #1;
    check("R8 ready low in flush", st_ready, 0);
    tick();
    flush = 1'b0; commit = 1'b0; st_valid = 1'b0;
    #1;
    check("R8 committed kept", commit_empty, 0);
    drain_one("R8 survivor", 64'h5000, 64'h1, 8'hFF);
    #1;
    check("R8 speculative gone", empty, 1);
    do_commit();
    #1;
    check("R11 idle commit", dc_req, 0);
  endtask

  task automatic t_alias();
    push(64'h6000, 64'h7, 2'd3);
    do_commit();
    push(64'h7008, 64'h8, 2'd2);
    chk_dw = 61'(64'h700F >> 3); #1;
    check("R9 hit speculative", chk_hit, 1);
    chk_dw = 61'(64'h6004 >> 3); #1;
    check("R9 hit committed", chk_hit, 1);
    chk_dw = 61'(64'h7010 >> 3); #1;
    check("R9 neighbour miss", chk_hit, 0);
    drain_one("R9 drain", 64'h6000, 64'h7, 8'hFF);
    chk_dw = 61'(64'h6000 >> 3); #1;
    check("R9 drained no hit", chk_hit, 0);
    flush = 1'b1; tick(); flush = 1'b0;
    chk_dw = 61'(64'h7008 >> 3); #1;
    check("R9 flushed no hit", chk_hit, 0);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; st_valid = 1'b0; commit = 1'b0; dc_gnt = 1'b0;
    st_addr = '0; st_data = '0; st_size = '0; chk_dw = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    tick();
    t_reset();
    t_spec_hold();
    t_byte_enables();
    t_misalign();
    t_full();
    t_flush();
    t_alias();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule